// File: doc/BRIEF.md
# Unlock-Sequence Flash Program/Erase Sequencer

This block drives an 8-bit parallel flash device that accepts commands only after a multi-write unlock preamble and that signals the end of an internal operation through the data it returns, not through a status register. A requester hands it one job at a time: a byte program (address and data) or a sector erase (any address inside the sector). The sequencer forms the chip base by clearing the low address bits that span one chip. It then plays the unlock and command writes with a fixed idle gap after each one, and polls the target location until the device reports completion or a timeout.

A failed attempt is retried within fixed limits. Between erase attempts the sequencer waits a long settle time. A failed program attempt is followed by a readback, which decides whether a retry is safe. Every job ends with the device back in read mode and a one-cycle completion pulse that carries a status code.

The device port is a simple synchronous bus. A write strobe lasts one cycle. A read strobe lasts one cycle, and the device returns its byte on `fl_rdata` in the following cycle, where the sequencer samples it.

Top module: `flseq_top`

## Requirements
- R1: After reset `busy`, `done`, `fl_we` and `fl_re` are 0. A request is taken only while `busy` is 0. A `req_valid` pulse while `busy` is 1 causes no device access and no extra `done`.
- R2: The chip base is `req_addr` with its low CHIP_AW bits cleared (CHIP_AW=17, so 0xA1234 gives 0xA0000). Unlock writes go to base+0x5555 and base+0x2AAA.
- R3: A program job first writes the reset sequence (0xAA@base+0x5555, 0x55@base+0x2AAA, 0xF0@base+0x5555). It then writes 0xAA@+0x5555, 0x55@+0x2AAA and 0xA0@+0x5555, followed by the data byte at the target address.
- R4: An erase attempt writes the reset sequence, then 0xAA@+0x5555, 0x55@+0x2AAA, 0x80@+0x5555, 0xAA@+0x5555 and 0x55@+0x2AAA, followed by 0x30 at the target address.
- R5: After every write at least GAP_CYC cycles pass with no strobe. A read strobe and a write strobe are never active in the same cycle.
- R6: After the erase command the sequencer reads the target until bit 3 reads 1. Reads are spaced by at least POLL_GAP idle cycles. If ACC_POLLS (10) reads show bit 3 as 0, the attempt fails.
- R7: Completion polling reads the target address. The operation is complete when read bit 7 equals bit 7 of the expected byte, which is the programmed data for a program and 0xFF for an erase. A mismatch with bit 5 clear causes another read.
- R8: A read whose bit 7 mismatches and whose bit 5 is 1 causes exactly one more read. If bit 7 of that read matches, the job succeeds; otherwise the attempt fails. When bit 7 matches, bit 5 is ignored.
- R9: On success the sequencer writes the read-mode sequence (0xAA@+0x5555, 0x55@+0x2AAA, 0xF0@+0x5555) and then reports status 0 (OK).
- R10: A failed program attempt writes the reset and read-mode sequences (six writes) and then reads the target. A readback other than 0xFF ends the job with status 2 (ABORT). Otherwise the four program writes are replayed with no reset in front. After PROG_TRIES (20) failed attempts the job ends with status 1 (FAIL), with no further writes.
- R11: A failed erase attempt waits SETTLE_CYC cycles. The next attempt begins again with the reset sequence. After ERASE_TRIES (11) failed attempts the sequencer writes the read-mode sequence and reports status 1 (FAIL).
- R12: `done` is a one-cycle pulse with `status` valid in the same cycle. In the next cycle `busy` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Job request, sampled while idle |
| req_erase | input | 1 | 1 = sector erase, 0 = byte program |
| req_addr | input | ADDR_W | Target byte or any address inside the sector |
| req_data | input | 8 | Byte to program |
| busy | output | 1 | A job is in progress |
| done | output | 1 | One-cycle job completion pulse |
| status | output | 2 | 0 OK, 1 FAIL, 2 ABORT; valid with done |
| fl_we | output | 1 | Device write strobe |
| fl_re | output | 1 | Device read strobe |
| fl_addr | output | ADDR_W | Device address |
| fl_wdata | output | 8 | Device write data |
| fl_rdata | input | 8 | Device read data, valid the cycle after fl_re |

## Verification
A new request can arrive in the same cycle as the completion pulse of the previous job. At that moment the sequencer is still busy, so the request must be dropped. The bench raises `req_valid` at the exact cycle where it sees `done`, then watches the device port for a long quiet window. Any write or read there is unexpected and is reported by the scoreboard, and `busy` must stay low. A second overlap is a single polled byte that shows both a matching bit 7 and a set bit 5. The bench feeds such a byte and expects immediate success with no extra read.

// File: rtl/flseq_pkg.sv
package flseq_pkg;

   typedef enum logic [1:0] {SC_RST, SC_PROG, SC_ERASE} script_t;

   typedef enum logic [3:0] {
      PH_PRE, PH_CMD, PH_ACC, PH_POLL, PH_RECHK,
      PH_FRST, PH_FRD, PH_VFY, PH_SETTLE, PH_FINAL
   } phase_t;

   typedef enum logic [2:0] {
      S_IDLE, S_WR, S_GAP, S_RD, S_RDW, S_ARM, S_WAIT, S_DONE
   } state_t;

   localparam logic [1:0] RES_OK    = 2'd0;
   localparam logic [1:0] RES_FAIL  = 2'd1;
   localparam logic [1:0] RES_ABORT = 2'd2;

   localparam logic [7:0] CMD_KEY1   = 8'hAA;
   localparam logic [7:0] CMD_KEY2   = 8'h55;
   localparam logic [7:0] CMD_WRBYTE = 8'hA0;
   localparam logic [7:0] CMD_ERSET  = 8'h80;
   localparam logic [7:0] CMD_SECTOR = 8'h30;
   localparam logic [7:0] CMD_ARRAY  = 8'hF0;
   localparam logic [7:0] BLANK      = 8'hFF;

   function automatic logic [2:0] script_last(script_t s);
      case (s)
         SC_PROG:  return 3'd3;
         SC_ERASE: return 3'd5;
         default:  return 3'd2;
      endcase
   endfunction

endpackage

// File: rtl/flseq_cmdgen.sv
module flseq_cmdgen
   import flseq_pkg::*;
#(
   parameter int ADDR_W  = 20,
   parameter int CHIP_AW = 17,
   parameter int UNLK_A  = 'h5555,
   parameter int UNLK_B  = 'h2AAA
) (
   input  script_t           scr,
   input  logic [2:0]        stp,
   input  logic [ADDR_W-1:0] tgt,
   input  logic [7:0]        pdata,
   output logic [ADDR_W-1:0] addr,
   output logic [7:0]        data
);
   logic [ADDR_W-1:0] base;
   logic [ADDR_W-1:0] ua;
   logic [ADDR_W-1:0] ub;

   generate
      if (CHIP_AW > ADDR_W) begin : g_bad_chip
         $error("CHIP_AW must not exceed ADDR_W");
      end
      if (UNLK_A >= (1 << CHIP_AW) || UNLK_B >= (1 << CHIP_AW)) begin : g_bad_unlk
         $error("unlock offsets must lie inside one chip");
      end
      if (ADDR_W > CHIP_AW) begin : g_banked
         assign base = {tgt[ADDR_W-1:CHIP_AW], {CHIP_AW{1'b0}}};
      end else begin : g_single
         assign base = '0;
      end
   endgenerate

   assign ua = base | ADDR_W'(UNLK_A);
   assign ub = base | ADDR_W'(UNLK_B);

   always_comb begin
      addr = ua;
      data = CMD_KEY1;
      case (stp)
         3'd0: begin addr = ua; data = CMD_KEY1; end
         3'd1: begin addr = ub; data = CMD_KEY2; end
         3'd2: begin
            addr = ua;
            case (scr)
               SC_PROG:  data = CMD_WRBYTE;
               SC_ERASE: data = CMD_ERSET;
               default:  data = CMD_ARRAY;
            endcase
         end
         3'd3: begin
            if (scr == SC_PROG) begin addr = tgt; data = pdata; end
            else                begin addr = ua;  data = CMD_KEY1; end
         end
         3'd4: begin addr = ub; data = CMD_KEY2; end
         default: begin addr = tgt; data = CMD_SECTOR; end
      endcase
   end
endmodule

// File: rtl/flseq_timer.sv
module flseq_timer #(
   parameter int CNT_W = 8
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             load,
   input  logic [CNT_W-1:0] value,
   output logic             zero
);
   logic [CNT_W-1:0] cnt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)            cnt <= '0;
      else if (load)         cnt <= value;
      else if (cnt != '0)    cnt <= cnt - 1'b1;
   end

   assign zero = (cnt == '0);
endmodule

// File: rtl/flseq_ctrl.sv
module flseq_ctrl
   import flseq_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int PROG_TRIES  = 20,
   parameter int ERASE_TRIES = 11,
   parameter int ACC_POLLS   = 10,
   parameter int GAP_CYC     = 4,
   parameter int POLL_GAP    = 20,
   parameter int SETTLE_CYC  = 1000,
   parameter int CNT_W       = 10
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_erase,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   output logic              busy,
   output logic              done,
   output logic [1:0]        status,
   output logic              fl_we,
   output logic              fl_re,
   input  logic [7:0]        fl_rdata,
   output logic [ADDR_W-1:0] cap_addr,
   output logic [7:0]        cap_data,
   output script_t           scr,
   output logic [2:0]        stp,
   output logic              tmr_load,
   output logic [CNT_W-1:0]  tmr_value,
   input  logic              tmr_zero
);
   localparam int MAXT  = (PROG_TRIES > ERASE_TRIES) ? PROG_TRIES : ERASE_TRIES;
   localparam int TRY_W = $clog2(MAXT + 1);
   localparam int ACC_W = $clog2(ACC_POLLS + 1);

   generate
      if (GAP_CYC < 1 || POLL_GAP < 1 || SETTLE_CYC < 1) begin : g_bad_wait
         $error("wait lengths must be at least one cycle");
      end
      if (PROG_TRIES < 1 || ERASE_TRIES < 1 || ACC_POLLS < 1) begin : g_bad_limit
         $error("retry limits must be at least one");
      end
   endgenerate

   state_t           st;
   phase_t           ph;
   logic             is_erase;
   logic [TRY_W-1:0] tries;
   logic [ACC_W-1:0] acc_cnt;
   logic [1:0]       res;
   logic [CNT_W-1:0] wait_len;
   logic             exp7, hit, rd_ok, rd_fail;

   assign busy      = (st != S_IDLE);
   assign done      = (st == S_DONE);
   assign status    = res;
   assign fl_we     = (st == S_WR);
   assign fl_re     = (st == S_RD);
   assign tmr_load  = (st == S_WR) || (st == S_ARM);
   assign tmr_value = (st == S_WR) ? CNT_W'(GAP_CYC) : wait_len;

   assign exp7 = is_erase ? 1'b1 : cap_data[7];
   assign hit  = (fl_rdata[7] == exp7);

   always_comb begin
      rd_ok   = 1'b0;
      rd_fail = 1'b0;
      if (st == S_RDW) begin
         case (ph)
            PH_POLL:  rd_ok = hit;
            PH_RECHK: begin rd_ok = hit; rd_fail = !hit; end
            PH_ACC:   rd_fail = !fl_rdata[3] && (acc_cnt == ACC_W'(ACC_POLLS - 1));
            default:  ;
         endcase
      end
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st       <= S_IDLE;
         ph       <= PH_PRE;
         scr      <= SC_RST;
         stp      <= '0;
         is_erase <= 1'b0;
         cap_addr <= '0;
         cap_data <= '0;
         tries    <= '0;
         acc_cnt  <= '0;
         res      <= RES_OK;
         wait_len <= '0;
      end else begin
         case (st)
            S_IDLE: if (req_valid) begin
               is_erase <= req_erase;
               cap_addr <= req_addr;
               cap_data <= req_data;
               tries    <= '0;
               res      <= RES_OK;
               ph       <= PH_PRE;
               scr      <= SC_RST;
               stp      <= '0;
               st       <= S_WR;
            end
            S_WR:  st <= S_GAP;
            S_GAP: if (tmr_zero) begin
               if (stp != script_last(scr)) begin
                  stp <= stp + 3'd1;
                  st  <= S_WR;
               end else begin
                  case (ph)
                     PH_PRE: begin
                        ph  <= PH_CMD;
                        scr <= is_erase ? SC_ERASE : SC_PROG;
                        stp <= '0;
                        st  <= S_WR;
                     end
                     PH_CMD: begin
                        acc_cnt <= '0;
                        ph      <= is_erase ? PH_ACC : PH_POLL;
                        st      <= S_RD;
                     end
                     PH_FRST: begin
                        ph  <= PH_FRD;
                        scr <= SC_RST;
                        stp <= '0;
                        st  <= S_WR;
                     end
                     PH_FRD: begin
                        ph <= PH_VFY;
                        st <= S_RD;
                     end
                     default: st <= S_DONE;
                  endcase
               end
            end
            S_RD:  st <= S_RDW;
            S_RDW: begin
               if (rd_ok) begin
                  res <= RES_OK;
                  ph  <= PH_FINAL;
                  scr <= SC_RST;
                  stp <= '0;
                  st  <= S_WR;
               end else if (rd_fail) begin
                  if (is_erase) begin
                     ph       <= PH_SETTLE;
                     wait_len <= CNT_W'(SETTLE_CYC);
                     st       <= S_ARM;
                  end else begin
                     ph  <= PH_FRST;
                     scr <= SC_RST;
                     stp <= '0;
                     st  <= S_WR;
                  end
               end else begin
                  case (ph)
                     PH_ACC: begin
                        if (fl_rdata[3]) begin
                           ph <= PH_POLL;
                           st <= S_RD;
                        end else begin
                           acc_cnt  <= acc_cnt + 1'b1;
                           wait_len <= CNT_W'(POLL_GAP);
                           st       <= S_ARM;
                        end
                     end
                     PH_POLL: begin
                        if (fl_rdata[5]) ph <= PH_RECHK;
                        st <= S_RD;
                     end
                     default: begin
                        if (fl_rdata != BLANK) begin
                           res <= RES_ABORT;
                           st  <= S_DONE;
                        end else if (tries == TRY_W'(PROG_TRIES - 1)) begin
                           res <= RES_FAIL;
                           st  <= S_DONE;
                        end else begin
                           tries <= tries + 1'b1;
                           ph    <= PH_CMD;
                           scr   <= SC_PROG;
                           stp   <= '0;
                           st    <= S_WR;
                        end
                     end
                  endcase
               end
            end
            S_ARM:  st <= S_WAIT;
            S_WAIT: if (tmr_zero) begin
               if (ph == PH_ACC) begin
                  st <= S_RD;
               end else if (tries == TRY_W'(ERASE_TRIES - 1)) begin
                  res <= RES_FAIL;
                  ph  <= PH_FINAL;
                  scr <= SC_RST;
                  stp <= '0;
                  st  <= S_WR;
               end else begin
                  tries <= tries + 1'b1;
                  ph    <= PH_PRE;
                  scr   <= SC_RST;
                  stp   <= '0;
                  st    <= S_WR;
               end
            end
            default: st <= S_IDLE;
         endcase
      end
   end

   assert_idle_quiet_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !busy |-> (!fl_we && !fl_re));
   assert_no_dual_strobe_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !(fl_we && fl_re));
   assert_write_gap_R5: assert property (@(posedge clk) disable iff (!rst_n)
      fl_we |=> (!fl_we && !fl_re));
   assert_accept_bound_R6: assert property (@(posedge clk) disable iff (!rst_n)
      acc_cnt < ACC_W'(ACC_POLLS));
   assert_try_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
      tries < TRY_W'(MAXT));
   assert_done_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> (!done && !busy));
   assert_status_code_R9: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> (status != 2'd3));
endmodule

// File: rtl/flseq_top.sv
module flseq_top
   import flseq_pkg::*;
#(
   parameter int ADDR_W      = 20,
   parameter int CHIP_AW     = 17,
   parameter int UNLK_A      = 'h5555,
   parameter int UNLK_B      = 'h2AAA,
   parameter int PROG_TRIES  = 20,
   parameter int ERASE_TRIES = 11,
   parameter int ACC_POLLS   = 10,
   parameter int GAP_CYC     = 4,
   parameter int POLL_GAP    = 20,
   parameter int SETTLE_CYC  = 1000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              req_valid,
   input  logic              req_erase,
   input  logic [ADDR_W-1:0] req_addr,
   input  logic [7:0]        req_data,
   output logic              busy,
   output logic              done,
   output logic [1:0]        status,
   output logic              fl_we,
   output logic              fl_re,
   output logic [ADDR_W-1:0] fl_addr,
   output logic [7:0]        fl_wdata,
   input  logic [7:0]        fl_rdata
);
   localparam int MAXW1 = (GAP_CYC > POLL_GAP) ? GAP_CYC : POLL_GAP;
   localparam int MAXW  = (MAXW1 > SETTLE_CYC) ? MAXW1 : SETTLE_CYC;
   localparam int CNT_W = $clog2(MAXW + 1);

   logic [ADDR_W-1:0] cap_addr, gen_addr;
   logic [7:0]        cap_data, gen_data;
   script_t           scr;
   logic [2:0]        stp;
   logic              tmr_load, tmr_zero;
   logic [CNT_W-1:0]  tmr_value;

   flseq_ctrl #(
      .ADDR_W(ADDR_W), .PROG_TRIES(PROG_TRIES), .ERASE_TRIES(ERASE_TRIES),
      .ACC_POLLS(ACC_POLLS), .GAP_CYC(GAP_CYC), .POLL_GAP(POLL_GAP),
      .SETTLE_CYC(SETTLE_CYC), .CNT_W(CNT_W)
   ) u_ctrl (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
      .status(status), .fl_we(fl_we), .fl_re(fl_re), .fl_rdata(fl_rdata),
      .cap_addr(cap_addr), .cap_data(cap_data), .scr(scr), .stp(stp),
      .tmr_load(tmr_load), .tmr_value(tmr_value), .tmr_zero(tmr_zero)
   );

   flseq_cmdgen #(
      .ADDR_W(ADDR_W), .CHIP_AW(CHIP_AW), .UNLK_A(UNLK_A), .UNLK_B(UNLK_B)
   ) u_cmdgen (
      .scr(scr), .stp(stp), .tgt(cap_addr), .pdata(cap_data),
      .addr(gen_addr), .data(gen_data)
   );

   flseq_timer #(.CNT_W(CNT_W)) u_timer (
      .clk(clk), .rst_n(rst_n), .load(tmr_load), .value(tmr_value), .zero(tmr_zero)
   );

   assign fl_addr  = fl_re ? cap_addr : gen_addr;
   assign fl_wdata = fl_we ? gen_data : 8'h00;

   assert_same_chip_R2: assert property (@(posedge clk) disable iff (!rst_n)
      fl_we |-> ((fl_addr >> CHIP_AW) == (cap_addr >> CHIP_AW)));
   assert_start_unlock_R3: assert property (@(posedge clk) disable iff (!rst_n)
      (fl_we && !$past(busy)) |-> (fl_wdata == CMD_KEY1));
endmodule

// File: tb/flseq_top_bench.sv
module flseq_top_bench;
   localparam int AW = 20;

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic          req_valid = 1'b0;
   logic          req_erase = 1'b0;
   logic [AW-1:0] req_addr = '0;
   logic [7:0]    req_data = '0;
   logic          busy, done, fl_we, fl_re;
   logic [1:0]    status;
   logic [AW-1:0] fl_addr;
   logic [7:0]    fl_wdata;
   logic [7:0]    fl_rdata = 8'h00;

   always #4 clk = ~clk;

   flseq_top #(.GAP_CYC(2), .POLL_GAP(3), .SETTLE_CYC(40)) u_flseq_top (
      .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_erase(req_erase),
      .req_addr(req_addr), .req_data(req_data), .busy(busy), .done(done),
      .status(status), .fl_we(fl_we), .fl_re(fl_re), .fl_addr(fl_addr),
      .fl_wdata(fl_wdata), .fl_rdata(fl_rdata)
   );

   int checks = 0;
   int fails  = 0;
   int done_cnt = 0;
   bit finished = 0;

   logic [AW-1:0] ew_a[$];
   logic [7:0]    ew_d[$];
   string         ew_t[$];
   logic [AW-1:0] er_a[$];
   logic [7:0]    er_v[$];
   logic [1:0]    es[$];
   string         es_t[$];

   task automatic chk(bit ok, string tag, string what, int act, int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
      end
   endtask

   task automatic push_w(logic [AW-1:0] a, logic [7:0] d, string t);
      ew_a.push_back(a); ew_d.push_back(d); ew_t.push_back(t);
   endtask
   task automatic push_seq3(logic [AW-1:0] b, logic [7:0] last, string t);
      push_w(b | 20'h05555, 8'hAA, t);
      push_w(b | 20'h02AAA, 8'h55, t);
      push_w(b | 20'h05555, last, t);
   endtask
   task automatic push_prog(logic [AW-1:0] b, logic [AW-1:0] a, logic [7:0] d);
      push_seq3(b, 8'hA0, "R3");
      push_w(a, d, "R3");
   endtask
   task automatic push_erase(logic [AW-1:0] b, logic [AW-1:0] a);
      push_seq3(b, 8'h80, "R4");
      push_w(b | 20'h05555, 8'hAA, "R4");
      push_w(b | 20'h02AAA, 8'h55, "R4");
      push_w(a, 8'h30, "R4");
   endtask
   task automatic push_r(logic [AW-1:0] a, logic [7:0] v);
      er_a.push_back(a); er_v.push_back(v);
   endtask
   task automatic push_res(logic [1:0] s, string t);
      es.push_back(s); es_t.push_back(t);
   endtask

   // monitor: pops expected device accesses and results
   always @(negedge clk) begin
      if (rst_n) begin
         if (fl_we) begin
            if (ew_a.size() == 0) chk(0, "R1", "unexpected write", int'(fl_addr), 0);
            else begin
               automatic logic [AW-1:0] a = ew_a.pop_front();
               automatic logic [7:0]    d = ew_d.pop_front();
               automatic string         t = ew_t.pop_front();
               chk(fl_addr == a, t, "write addr", int'(fl_addr), int'(a));
               chk(fl_wdata == d, t, "write data", int'(fl_wdata), int'(d));
            end
         end
         if (fl_re) begin
            if (er_a.size() == 0) chk(0, "R7", "unexpected read", int'(fl_addr), 0);
            else begin
               automatic logic [AW-1:0] a = er_a.pop_front();
               chk(fl_addr == a, "R7", "read addr", int'(fl_addr), int'(a));
               fl_rdata = er_v.pop_front();
            end
         end
         if (done) begin
            done_cnt++;
            if (es.size() == 0) chk(0, "R12", "unexpected done", int'(status), 0);
            else begin
               automatic logic [1:0] s = es.pop_front();
               automatic string      t = es_t.pop_front();
               chk(status == s, t, "status", int'(status), int'(s));
            end
         end
      end
   end

   task automatic start_op(bit er, logic [AW-1:0] a, logic [7:0] d);
      @(negedge clk);
      req_valid = 1'b1; req_erase = er; req_addr = a; req_data = d;
      @(negedge clk);
      req_valid = 1'b0;
   endtask

   task automatic finish_op(string t);
      int c = done_cnt;
      while (done_cnt == c) @(negedge clk);
      @(negedge clk);
      chk(busy == 1'b0, "R12", "busy after done", int'(busy), 0);
      chk(ew_a.size() == 0 && er_a.size() == 0, t, "left-over accesses",
          ew_a.size() + er_a.size(), 0);
   endtask

   initial begin
      repeat (150000) @(posedge clk);
      if (!finished) begin
         checks++; fails++;
         $display("FAIL watchdog expired");
         $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
         $finish;
      end
   end

   initial begin
      logic [AW-1:0] pa, pb, ea, eb;
      pa = 20'hA1234; pb = 20'hA0000;
      ea = 20'h3C010; eb = 20'h20000;

      repeat (3) @(negedge clk);
      chk(busy == 0 && done == 0 && fl_we == 0 && fl_re == 0, "R1", "reset outputs",
          {busy, done, fl_we, fl_re}, 0);
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R3 R2 R9: program, done on first poll
      push_seq3(pb, 8'hF0, "R3"); push_prog(pb, pa, 8'h5A);
      push_r(pa, 8'h5A); push_seq3(pb, 8'hF0, "R9"); push_res(2'd0, "R9");
      start_op(0, pa, 8'h5A); finish_op("R3");

      // R7: busy polls then match (bit5 clear)
      push_seq3(20'h0, 8'hF0, "R3"); push_prog(20'h0, 20'h04321, 8'hC3);
      push_r(20'h04321, 8'h00); push_r(20'h04321, 8'h11); push_r(20'h04321, 8'hC3);
      push_seq3(20'h0, 8'hF0, "R9"); push_res(2'd0, "R7");
      start_op(0, 20'h04321, 8'hC3); finish_op("R7");

      // R8: bit5 set with bit7 matching -> success, no extra read
      push_seq3(pb, 8'hF0, "R3"); push_prog(pb, pa, 8'h5A);
      push_r(pa, 8'h7A); push_seq3(pb, 8'hF0, "R9"); push_res(2'd0, "R8");
      start_op(0, pa, 8'h5A); finish_op("R8");

      // R8: bit5 then matching recheck -> success
      push_seq3(pb, 8'hF0, "R3"); push_prog(pb, pa, 8'h5A);
      push_r(pa, 8'hA0); push_r(pa, 8'h5A); push_seq3(pb, 8'hF0, "R9");
      push_res(2'd0, "R8");
      start_op(0, pa, 8'h5A); finish_op("R8");

      // R10: failed attempt, blank readback, retry succeeds
      push_seq3(pb, 8'hF0, "R3"); push_prog(pb, pa, 8'h5A);
      push_r(pa, 8'hA0); push_r(pa, 8'h80);
      push_seq3(pb, 8'hF0, "R10"); push_seq3(pb, 8'hF0, "R10"); push_r(pa, 8'hFF);
      push_prog(pb, pa, 8'h5A); push_r(pa, 8'h5A);
      push_seq3(pb, 8'hF0, "R9"); push_res(2'd0, "R10");
      start_op(0, pa, 8'h5A); finish_op("R10");

      // R10: partial write readback -> abort
      push_seq3(pb, 8'hF0, "R3"); push_prog(pb, pa, 8'h5A);
      push_r(pa, 8'hA0); push_r(pa, 8'h80);
      push_seq3(pb, 8'hF0, "R10"); push_seq3(pb, 8'hF0, "R10"); push_r(pa, 8'h12);
      push_res(2'd2, "R10");
      start_op(0, pa, 8'h5A); finish_op("R10");

      // R10: twenty failed attempts -> fail
      push_seq3(pb, 8'hF0, "R3");
      for (int k = 0; k < 20; k++) begin
         push_prog(pb, pa, 8'h5A); push_r(pa, 8'hA0); push_r(pa, 8'h80);
         push_seq3(pb, 8'hF0, "R10"); push_seq3(pb, 8'hF0, "R10"); push_r(pa, 8'hFF);
      end
      push_res(2'd1, "R10");
      start_op(0, pa, 8'h5A); finish_op("R10");

      // R4 R6: erase accepted on second read, then done
      push_seq3(eb, 8'hF0, "R4"); push_erase(eb, ea);
      push_r(ea, 8'h00); push_r(ea, 8'h08); push_r(ea, 8'h08); push_r(ea, 8'hFF);
      push_seq3(eb, 8'hF0, "R9"); push_res(2'd0, "R6");
      start_op(1, ea, 8'h00); finish_op("R6");

      // R11 R8: bit5 timeout on first attempt, second attempt succeeds
      push_seq3(eb, 8'hF0, "R11"); push_erase(eb, ea);
      push_r(ea, 8'h08); push_r(ea, 8'h28); push_r(ea, 8'h08);
      push_seq3(eb, 8'hF0, "R11"); push_erase(eb, ea);
      push_r(ea, 8'h08); push_r(ea, 8'hFF);
      push_seq3(eb, 8'hF0, "R9"); push_res(2'd0, "R11");
      start_op(1, ea, 8'h00); finish_op("R11");

      // R6 R11: never accepted, eleven attempts -> fail
      for (int k = 0; k < 11; k++) begin
         push_seq3(eb, 8'hF0, "R11"); push_erase(eb, ea);
         for (int j = 0; j < 10; j++) push_r(ea, 8'h00);
      end
      push_seq3(eb, 8'hF0, "R11"); push_res(2'd1, "R6");
      start_op(1, ea, 8'h00); finish_op("R11");

      // R1: request while busy is ignored
      push_seq3(pb, 8'hF0, "R3"); push_prog(pb, pa, 8'h5A);
      push_r(pa, 8'h80); push_r(pa, 8'h80); push_r(pa, 8'h5A);
      push_seq3(pb, 8'hF0, "R9"); push_res(2'd0, "R1");
      start_op(0, pa, 8'h5A);
      repeat (5) @(negedge clk);
      start_op(1, ea, 8'h00);
      finish_op("R1");

      // R12 R1: request in the done cycle is dropped
      push_seq3(pb, 8'hF0, "R3"); push_prog(pb, pa, 8'h5A);
      push_r(pa, 8'h5A); push_seq3(pb, 8'hF0, "R9"); push_res(2'd0, "R12");
      start_op(0, pa, 8'h5A);
      while (done !== 1'b1) @(negedge clk);
      req_valid = 1'b1; req_erase = 1'b1; req_addr = ea;
      @(negedge clk);
      req_valid = 1'b0;
      repeat (40) @(negedge clk);
      chk(busy == 1'b0, "R12", "busy after dropped request", int'(busy), 0);
      chk(ew_a.size() == 0 && er_a.size() == 0, "R1", "queues after drop",
          ew_a.size() + er_a.size(), 0);

      finished = 1;
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule